// File: doc/BRIEF.md
# Reconfigurable Direct-Mapped Cache Controller

This block holds the tag, valid and storage control for a small on-chip cache. One array of 128 lines of 16 bytes, 2 KB in all, can run in four ways: as an instruction cache, as a write-through data cache, split into an instruction half and a data half, or turned off completely. An instruction-fetch port and a data load/store port share the array. Both ports share a single-word bus port that carries line fills, single-word reads and write-through stores. Only one bus transaction is in flight at a time.

A configuration write sets the enable, the mode and the line-fill policy in one step, and it can also start an invalidate-all. The invalidate walks the valid bits one index per clock. While a walk, a fill or any bus transaction is in progress, `busy` is high, new requests are stalled, and configuration writes are dropped. A mode therefore never changes under a fill in progress. After a mode change, software issues an invalidate-all so that entries left by the previous layout are never hit.

Top module: `cfg_cache_ctrl`

## Requirements
- R1: With `cfg_enable`=0, or with mode code 11, every load and every fetch is a single-word bus read and nothing is allocated. A repeated access goes to the bus again.
- R2: Mode code 00 (split) works as follows. Fetches use lines 0..63, indexed by address bits [9:4]. Data accesses use lines 64..127, also indexed by bits [9:4]. An instruction line and a data line with the same bits [9:4] can be held and hit at the same time.
- R3: Mode code 01 (instruction only) indexes fetches over all 128 lines by bits [10:4]. Two fetch lines that differ only in bit 10 both stay resident. Data loads are uncached single-word reads.
- R4: Mode code 10 (data only) indexes data over all 128 lines by bits [10:4]. Fetches are uncached single-word reads.
- R5: Every store is exactly one bus write of the store address and data. A store that hits updates the cached word, and the next load returns the new value with no bus traffic. A store that misses allocates nothing.
- R6: In split mode an invalidate-all takes the mask bits `cfg_skip_i` and `cfg_skip_d`. With 00 it clears all 128 lines in 128 busy cycles. With 10 it clears only the data half in 64 cycles. With 01 it clears only the instruction half in 64 cycles. With 11 it clears nothing and takes 0 busy cycles.
- R7: In modes 01 and 10 an invalidate-all clears all 128 lines in 128 busy cycles, whatever the mask bits are.
- R8: The fill field selects the fill policy on a miss. Code 00 fills the whole line for any word offset. Code 01 fills the whole line for offsets 0..2 and makes a single-word read with no allocation for offset 3. Codes 10 and 11 always make a single-word read with no allocation.
- R9: A whole-line fill makes four bus reads. It starts at the missed word and wraps in offset order (o, o+1, o+2, o+3 mod 4).
- R10: `busy` is 0 after reset. The invalidate walk clears one line per clock, and no request is answered while `busy` is high.
- R11: A configuration write made while `busy` is high has no effect.
- R12: After a mode change followed by an invalidate-all, an access to a line that was cached under the old layout misses.
- R13: When both ports request in the same idle cycle, the fetch port is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Global cache enable |
| cfg_mode | input | 2 | 00 split, 01 instruction only, 10 data only, 11 off |
| cfg_fill | input | 2 | Line-fill policy |
| cfg_inv | input | 1 | Start invalidate-all with this write |
| cfg_skip_i | input | 1 | Split mode: leave instruction half valid |
| cfg_skip_d | input | 1 | Split mode: leave data half valid |
| busy | output | 1 | Walk, fill or bus transaction in progress |
| i_req | input | 1 | Fetch request, held until ready |
| i_addr | input | 32 | Fetch byte address, word aligned |
| i_ready | output | 1 | Fetch complete this cycle |
| i_rdata | output | 32 | Fetched word |
| d_req | input | 1 | Data request, held until ready |
| d_we | input | 1 | 1 for store |
| d_addr | input | 32 | Data byte address, word aligned |
| d_wdata | input | 32 | Store data |
| d_ready | output | 1 | Data access complete this cycle |
| d_rdata | output | 32 | Loaded word |
| bus_req | output | 1 | Bus word request |
| bus_we | output | 1 | Bus write |
| bus_addr | output | 32 | Bus word address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus transaction done this cycle |
| bus_rdata | input | 32 | Bus read data |

## Verification
A configuration write can arrive in the same cycle as an ongoing line fill or invalidate walk. The bench provokes this by pulsing a write that turns the cache off while a data fill is halfway through its four bus reads, and again while a walk is running. It then judges the outcome at the ports: a repeat of the access must hit with no bus traffic, which shows that the cache is still on. The second collision is two requests arriving together. The bench checks that the fetch completes first and the load completes one cycle later.

// File: rtl/ccache_pkg.sv
package ccache_pkg;

    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int LINES  = 128;
    parameter int WORDS  = 4;

    localparam int BL    = $clog2(DATA_W / 8);
    localparam int OFF_W = $clog2(WORDS);
    localparam int LO    = BL + OFF_W;
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - LO - (IDX_W - 1);
    localparam int WA_W  = ADDR_W - BL;

    typedef enum logic [1:0] {
        MODE_SPLIT  = 2'b00,
        MODE_ICACHE = 2'b01,
        MODE_DCACHE = 2'b10,
        MODE_OFF    = 2'b11
    } mode_e;

    typedef enum logic [1:0] {ST_IDLE, ST_INV, ST_BUS, ST_FILL} state_e;

    typedef struct packed {
        logic       en;
        mode_e      mode;
        logic [1:0] fill;
    } cfg_t;

    typedef struct packed {
        logic             go;
        logic [IDX_W-1:0] lo;
        logic [IDX_W-1:0] hi;
    } span_t;

    function automatic logic [IDX_W-1:0] line_index(mode_e m, logic is_data,
                                                   logic [ADDR_W-1:0] a);
        if (m == MODE_SPLIT) return {is_data, a[LO+IDX_W-2:LO]};
        return a[LO+IDX_W-1:LO];
    endfunction

    function automatic logic fill_whole(logic [1:0] pol, logic [OFF_W-1:0] off);
        if (pol == 2'b00) return 1'b1;
        if (pol == 2'b01) return off != '1;
        return 1'b0;
    endfunction

    function automatic span_t inv_span(mode_e m, logic skip_i, logic skip_d);
        span_t s;
        s.go = 1'b1;
        s.lo = '0;
        s.hi = '1;
        if (m == MODE_SPLIT) begin
            case ({skip_i, skip_d})
                2'b10:   s.lo = {1'b1, {(IDX_W-1){1'b0}}};
                2'b01:   s.hi = {1'b0, {(IDX_W-1){1'b1}}};
                2'b11:   s.go = 1'b0;
                default: ;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/ccache_store.sv
module ccache_store #(
    parameter int LINES  = 128,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 22,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [OFF_W-1:0]  ra_off,
    output logic              ra_valid,
    output logic [TAG_W-1:0]  ra_tag,
    output logic [DATA_W-1:0] ra_word,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [OFF_W-1:0]  rb_off,
    output logic              rb_valid,
    output logic [TAG_W-1:0]  rb_tag,
    output logic [DATA_W-1:0] rb_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [TAG_W-1:0]  set_tag,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);
    logic              valid [LINES];
    logic [TAG_W-1:0]  tags  [LINES];
    logic [DATA_W-1:0] words [LINES][WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) valid[i] <= 1'b0;
        end else begin
            if (clr_en) valid[clr_idx] <= 1'b0;
            if (set_en) valid[set_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) tags[set_idx] <= set_tag;
        if (wr_en)  words[wr_idx][wr_off] <= wr_data;
    end

    assign ra_valid = valid[ra_idx];
    assign ra_tag   = tags[ra_idx];
    assign ra_word  = words[ra_idx][ra_off];
    assign rb_valid = valid[rb_idx];
    assign rb_tag   = tags[rb_idx];
    assign rb_word  = words[rb_idx][rb_off];

    AST_SET_CLEAR_APART: assert property (@(posedge clk) disable iff (rst)
        !(set_en && clr_en)) else $error("valid set and clear together"); // R10

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        set_en |=> valid[$past(set_idx)]) else $error("line not valid after fill"); // R9
endmodule

// File: rtl/ccache_walker.sv
module ccache_walker #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] lo,
    input  logic [IDX_W-1:0] hi,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            stop   <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= lo;
            stop   <= hi;
        end else if (active) begin
            if (idx == stop) active <= 1'b0;
            else             idx    <= idx + 1'b1;
        end
    end

    assign last = active && (idx == stop);

    AST_WALK_ONE_PER_CLOCK: assert property (@(posedge clk) disable iff (rst)
        active && !last |=> active && idx == $past(idx) + 1'b1)
        else $error("walk skipped an index"); // R10
endmodule

// File: rtl/cfg_cache_ctrl.sv
module cfg_cache_ctrl
    import ccache_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic        cfg_enable,
    input  logic [1:0]  cfg_mode,
    input  logic [1:0]  cfg_fill,
    input  logic        cfg_inv,
    input  logic        cfg_skip_i,
    input  logic        cfg_skip_d,
    output logic        busy,
    input  logic        i_req,
    input  logic [31:0] i_addr,
    output logic        i_ready,
    output logic [31:0] i_rdata,
    input  logic        d_req,
    input  logic        d_we,
    input  logic [31:0] d_addr,
    input  logic [31:0] d_wdata,
    output logic        d_ready,
    output logic [31:0] d_rdata,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata
);
    state_e            state;
    cfg_t              cfg_q;
    logic              cur_d, cur_we;
    logic [WA_W-1:0]   cur_wa;
    logic [DATA_W-1:0] cur_wdata;
    logic [IDX_W-1:0]  cur_idx;
    logic [OFF_W-1:0]  cur_k;

    logic cache_i, cache_d, i_hit, d_hit, idle, take_cfg, serve_i, serve_d;
    logic i_valid, d_valid, fill_start, go_fill, go_bus;
    logic [TAG_W-1:0]  i_tag, d_tag;
    logic [DATA_W-1:0] i_word, d_word;
    logic [IDX_W-1:0]  i_idx, d_idx, start_idx;
    logic [OFF_W-1:0]  i_off, d_off, fill_off;
    span_t             span;
    logic              walk_on, walk_last;
    logic [IDX_W-1:0]  walk_idx;
    logic              wr_en, set_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [OFF_W-1:0]  wr_off;
    logic [DATA_W-1:0] wr_data;

    assign cache_i = cfg_q.en && (cfg_q.mode == MODE_SPLIT || cfg_q.mode == MODE_ICACHE);
    assign cache_d = cfg_q.en && (cfg_q.mode == MODE_SPLIT || cfg_q.mode == MODE_DCACHE);
    assign i_idx   = line_index(cfg_q.mode, 1'b0, i_addr);
    assign d_idx   = line_index(cfg_q.mode, 1'b1, d_addr);
    assign i_off   = i_addr[LO-1:BL];
    assign d_off   = d_addr[LO-1:BL];
    assign i_hit   = cache_i && i_valid && i_tag == i_addr[ADDR_W-1 -: TAG_W];
    assign d_hit   = cache_d && d_valid && d_tag == d_addr[ADDR_W-1 -: TAG_W];

    assign idle     = state == ST_IDLE;
    assign busy     = !idle;
    assign take_cfg = idle && cfg_wr;
    assign serve_i  = idle && !cfg_wr && i_req;
    assign serve_d  = idle && !cfg_wr && !i_req && d_req;
    assign span     = inv_span(mode_e'(cfg_mode), cfg_skip_i, cfg_skip_d);

    // miss decision for whichever port is being served this cycle
    always_comb begin
        go_fill   = 1'b0;
        go_bus    = 1'b0;
        start_idx = i_idx;
        if (serve_i && !i_hit) begin
            go_fill = cache_i && fill_whole(cfg_q.fill, i_off);
            go_bus  = !go_fill;
        end else if (serve_d && (d_we || !d_hit)) begin
            start_idx = d_idx;
            go_fill   = !d_we && cache_d && fill_whole(cfg_q.fill, d_off);
            go_bus    = !go_fill;
        end
    end
    assign fill_start = go_fill;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cfg_q     <= '{en: 1'b0, mode: MODE_SPLIT, fill: 2'b00};
            cur_d     <= 1'b0;
            cur_we    <= 1'b0;
            cur_wa    <= '0;
            cur_wdata <= '0;
            cur_idx   <= '0;
            cur_k     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take_cfg) begin
                        cfg_q <= '{en: cfg_enable, mode: mode_e'(cfg_mode), fill: cfg_fill};
                        if (cfg_inv && span.go) state <= ST_INV;
                    end else if (go_fill || go_bus) begin
                        cur_d     <= !serve_i;
                        cur_we    <= !serve_i && d_we;
                        cur_wa    <= serve_i ? i_addr[ADDR_W-1:BL] : d_addr[ADDR_W-1:BL];
                        cur_wdata <= d_wdata;
                        cur_idx   <= start_idx;
                        cur_k     <= '0;
                        state     <= go_fill ? ST_FILL : ST_BUS;
                    end
                end
                ST_INV:  if (walk_last) state <= ST_IDLE;
                ST_BUS:  if (bus_ack) state <= ST_IDLE;
                ST_FILL: if (bus_ack) begin
                    cur_k <= cur_k + 1'b1;
                    if (cur_k == '1) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign fill_off  = cur_wa[OFF_W-1:0] + cur_k;
    assign bus_req   = state == ST_BUS || state == ST_FILL;
    assign bus_we    = state == ST_BUS && cur_we;
    assign bus_wdata = cur_wdata;
    assign bus_addr  = (state == ST_FILL)
                     ? {cur_wa[WA_W-1:OFF_W], fill_off, {BL{1'b0}}}
                     : {cur_wa, {BL{1'b0}}};

    assign i_ready = (serve_i && i_hit) || (state == ST_BUS && !cur_d && bus_ack);
    assign d_ready = (serve_d && !d_we && d_hit) || (state == ST_BUS && cur_d && bus_ack);
    assign i_rdata = (state == ST_BUS) ? bus_rdata : i_word;
    assign d_rdata = (state == ST_BUS) ? bus_rdata : d_word;

    // array writes: fill words, or a store-hit word update during its bus write
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = cur_idx;
        wr_off  = fill_off;
        wr_data = bus_rdata;
        if (state == ST_FILL && bus_ack) begin
            wr_en = 1'b1;
        end else if (state == ST_BUS && cur_we && bus_ack && d_hit) begin
            wr_en   = 1'b1;
            wr_idx  = d_idx;
            wr_off  = d_off;
            wr_data = cur_wdata;
        end
    end
    assign set_en = state == ST_FILL && bus_ack && cur_k == '1;

    ccache_walker #(.IDX_W(IDX_W)) u_walk (
        .clk(clk), .rst(rst), .start(take_cfg && cfg_inv && span.go),
        .lo(span.lo), .hi(span.hi), .active(walk_on), .idx(walk_idx), .last(walk_last)
    );

    ccache_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst(rst),
        .ra_idx(i_idx), .ra_off(i_off), .ra_valid(i_valid), .ra_tag(i_tag), .ra_word(i_word),
        .rb_idx(d_idx), .rb_off(d_off), .rb_valid(d_valid), .rb_tag(d_tag), .rb_word(d_word),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off), .wr_data(wr_data),
        .set_en(set_en), .set_idx(cur_idx), .set_tag(cur_wa[WA_W-1 -: TAG_W]),
        .clr_en(walk_on || fill_start), .clr_idx(walk_on ? walk_idx : start_idx)
    );

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (i_req |-> i_addr[BL-1:0] == '0) and (d_req |-> d_addr[BL-1:0] == '0))
        else $error("unaligned request"); // R9
    AST_OFF_GOES_TO_BUS: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.en && (i_ready || d_ready)) |-> bus_ack) else $error("hit while off"); // R1
    AST_STORE_WRITES_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (d_ready && d_we) |-> (bus_req && bus_we && bus_ack)) else $error("store not on bus"); // R5
    AST_FILL_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL && bus_ack && cur_k != '1) |=>
        bus_addr[LO-1:BL] == $past(bus_addr[LO-1:BL]) + 1'b1) else $error("fill order"); // R9
    AST_CFG_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q)) else $error("config changed while busy"); // R11
    AST_WALK_STALLS: assert property (@(posedge clk) disable iff (rst)
        walk_on |-> !(i_ready || d_ready)) else $error("answer during walk"); // R10
endmodule

// File: tb/tb_cfg_cache_ctrl.sv
module tb_cfg_cache_ctrl;
    logic clk = 1'b0, rst = 1'b1;
    logic cfg_wr = 0, cfg_enable = 0, cfg_inv = 0, cfg_skip_i = 0, cfg_skip_d = 0;
    logic [1:0] cfg_mode = 0, cfg_fill = 0;
    logic busy;
    logic i_req = 0, d_req = 0, d_we = 0, i_ready, d_ready;
    logic [31:0] i_addr = 0, d_addr = 0, d_wdata = 0, i_rdata, d_rdata;
    logic bus_req, bus_we, bus_ack = 0;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;

    always #5 clk = ~clk;

    cfg_cache_ctrl dut (.*);

    typedef struct { logic [31:0] addr; logic we; logic [31:0] data; } tx_t;
    tx_t txq[$];
    logic [31:0] memw [int];
    int nchk = 0, nfail = 0;

    // reference state: what the cache should hold, by line address
    bit mv [128];
    logic [27:0] mline [128];
    bit en_m = 0;
    int mode_m = 0, fill_m = 0;

    function automatic logic [31:0] mem_rd(logic [31:0] a);
        if (memw.exists(int'(a >> 2))) return memw[int'(a >> 2)];
        return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    function automatic int idx_of(bit isd, logic [31:0] a);
        if (mode_m == 0) return (isd ? 64 : 0) + int'(a[9:4]);
        return int'(a[10:4]);
    endfunction

    function automatic bit cached(bit isd);
        return en_m && (mode_m == 0 || mode_m == (isd ? 2 : 1));
    endfunction

    task automatic check(bit ok, string rq, string what, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // bus responder: ack one cycle after a request is seen, then drop
    always @(posedge clk) begin
        #2;
        if (bus_req && !bus_ack) begin
            bus_ack   = 1'b1;
            bus_rdata = mem_rd(bus_addr);
        end else bus_ack = 1'b0;
    end

    always @(negedge clk) begin
        if (bus_req && bus_ack) begin
            txq.push_back('{addr: bus_addr, we: bus_we, data: bus_wdata});
            if (bus_we) memw[int'(bus_addr >> 2)] = bus_wdata;
        end
        if (!rst && ((i_ready && !i_req) || (d_ready && !d_req)))
            check(0, "R13", "ready without request", 1, 0);
    end

    task automatic cfg_write(bit en, int mode, int fill, bit inv, bit si, bit sd,
                             int exp_cycles, string rq);
        int cnt = 0;
        @(posedge clk); #1;
        cfg_wr = 1; cfg_enable = en; cfg_mode = 2'(mode); cfg_fill = 2'(fill);
        cfg_inv = inv; cfg_skip_i = si; cfg_skip_d = sd;
        @(posedge clk); #1;
        cfg_wr = 0;
        en_m = en; mode_m = mode; fill_m = fill;
        if (inv) begin
            int lo = 0, hi = 127;
            if (mode == 0 && si && !sd) lo = 64;
            if (mode == 0 && sd && !si) hi = 63;
            if (mode == 0 && si && sd) hi = -1;
            for (int i = lo; i <= hi; i++) mv[i] = 0;
        end
        forever begin
            @(negedge clk);
            if (!busy || cnt > 300) break;
            cnt++;
        end
        check(cnt == exp_cycles, rq, "invalidate busy cycles", cnt, exp_cycles);
    endtask

    task automatic cfg_pulse(bit en, int mode);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_enable = en; cfg_mode = 2'(mode); cfg_inv = 1;
        @(posedge clk); #1;
        cfg_wr = 0; cfg_inv = 0;
    endtask

    task automatic access(bit isd, bit we, logic [31:0] a, logic [31:0] wd, string rq);
        logic [31:0] got = 0, expd;
        int n_exp, idx, off, w;
        bit c, hit, whole;
        c = cached(isd); idx = idx_of(isd, a); off = int'(a[3:2]);
        hit = c && mv[idx] && mline[idx] == a[31:4];
        whole = (fill_m == 0) || (fill_m == 1 && off != 3);
        expd = mem_rd(a);
        n_exp = we ? 1 : hit ? 0 : (c && whole) ? 4 : 1;
        if (!we && c && !hit && whole) begin mv[idx] = 1; mline[idx] = a[31:4]; end
        txq.delete();
        @(posedge clk); #1;
        if (isd) begin d_req = 1; d_we = we; d_addr = a; d_wdata = wd; end
        else begin i_req = 1; i_addr = a; end
        w = 0;
        forever begin
            @(negedge clk);
            if (isd ? d_ready : i_ready) begin got = isd ? d_rdata : i_rdata; break; end
            if (++w > 60) begin check(0, rq, "access timeout", w, 0); break; end
        end
        @(posedge clk); #1;
        i_req = 0; d_req = 0; d_we = 0;
        check(txq.size() == n_exp, rq, "bus words", txq.size(), n_exp);
        if (!we) check(got == expd, rq, "read data", got, expd);
        if (n_exp == 4 && txq.size() == 4)
            for (int k = 0; k < 4; k++) begin
                logic [31:0] ea = {a[31:4], 2'((off + k) % 4), 2'b00};
                check(txq[k].addr == ea && !txq[k].we, "R9", "wrap address", txq[k].addr, ea);
            end
        if (we && txq.size() == 1)
            check(txq[0].we && txq[0].addr == a && txq[0].data == wd, rq,
                  "store write-through", txq[0].data, wd);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R10", "watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin mv[i] = 0; mline[i] = 0; end
        repeat (3) @(posedge clk); #1;
        rst = 0;
        @(negedge clk);
        check(busy == 0 && bus_req == 0 && i_ready == 0 && d_ready == 0,
              "R10", "reset state", {busy, bus_req, i_ready, d_ready}, 0);

        // R1: cache off
        access(0, 0, 32'h0000_1000, 0, "R1");
        access(0, 0, 32'h0000_1000, 0, "R1");
        access(1, 0, 32'h0000_3000, 0, "R1");
        access(1, 1, 32'h0000_3010, 32'h1111_2222, "R1");
        cfg_write(1, 3, 0, 0, 0, 0, 0, "R1");
        access(0, 0, 32'h0000_1000, 0, "R1");
        access(0, 0, 32'h0000_1000, 0, "R1");

        // split mode
        cfg_write(1, 0, 0, 1, 0, 0, 128, "R6");
        access(0, 0, 32'h0000_1000, 0, "R2");
        access(0, 0, 32'h0000_1000, 0, "R2");
        access(0, 0, 32'h0000_2008, 0, "R9");
        access(1, 0, 32'h0000_3000, 0, "R2");
        access(0, 0, 32'h0000_2008, 0, "R2");
        access(1, 0, 32'h0000_3000, 0, "R2");

        // R5: write-through
        access(1, 1, 32'h0000_3004, 32'hCAFE_0001, "R5");
        access(1, 0, 32'h0000_3004, 0, "R5");
        access(1, 1, 32'h0000_5000, 32'hBEEF_0002, "R5");
        access(1, 0, 32'h0000_5000, 0, "R5");

        // R6: masked invalidates in split mode
        access(1, 0, 32'h0000_3000, 0, "R6");
        cfg_write(1, 0, 0, 1, 1, 0, 64, "R6");
        access(0, 0, 32'h0000_2008, 0, "R6");
        access(1, 0, 32'h0000_3000, 0, "R6");
        cfg_write(1, 0, 0, 1, 0, 1, 64, "R6");
        access(0, 0, 32'h0000_2008, 0, "R6");
        access(1, 0, 32'h0000_3000, 0, "R6");
        cfg_write(1, 0, 0, 1, 1, 1, 0, "R6");
        access(0, 0, 32'h0000_2008, 0, "R6");

        // R8: fill policy
        cfg_write(1, 0, 1, 0, 0, 0, 0, "R8");
        access(0, 0, 32'h0000_400C, 0, "R8");
        access(0, 0, 32'h0000_400C, 0, "R8");
        access(0, 0, 32'h0000_4008, 0, "R8");
        access(0, 0, 32'h0000_4008, 0, "R8");
        cfg_write(1, 0, 2, 0, 0, 0, 0, "R8");
        access(0, 0, 32'h0000_6000, 0, "R8");
        access(0, 0, 32'h0000_6000, 0, "R8");
        cfg_write(1, 0, 3, 0, 0, 0, 0, "R8");
        access(1, 0, 32'h0000_6100, 0, "R8");

        // instruction only, masks ignored, stale lines gone
        cfg_write(1, 1, 0, 1, 1, 1, 128, "R7");
        access(0, 0, 32'h0000_2008, 0, "R12");
        access(0, 0, 32'h0000_2408, 0, "R3");
        access(0, 0, 32'h0000_2008, 0, "R3");
        access(0, 0, 32'h0000_2408, 0, "R3");
        access(1, 0, 32'h0000_3000, 0, "R3");
        access(1, 0, 32'h0000_3000, 0, "R3");

        // data only
        cfg_write(1, 2, 0, 1, 1, 0, 128, "R7");
        access(0, 0, 32'h0000_2008, 0, "R4");
        access(0, 0, 32'h0000_2008, 0, "R4");
        access(1, 0, 32'h0000_3000, 0, "R12");
        access(1, 0, 32'h0000_3400, 0, "R4");
        access(1, 0, 32'h0000_3000, 0, "R4");
        access(1, 0, 32'h0000_3400, 0, "R4");

        // R11: config write during a walk and during a fill
        fork
            cfg_write(1, 2, 0, 1, 0, 0, 128, "R11");
            begin repeat (10) @(posedge clk); cfg_pulse(0, 0); end
        join
        access(1, 0, 32'h0000_3000, 0, "R11");
        access(1, 0, 32'h0000_3000, 0, "R11");
        fork
            access(1, 0, 32'h0000_3800, 0, "R11");
            begin repeat (3) @(posedge clk); cfg_pulse(0, 0); end
        join
        access(1, 0, 32'h0000_3800, 0, "R11");

        // R13: both ports hit in the same cycle
        cfg_write(1, 0, 0, 1, 0, 0, 128, "R13");
        access(0, 0, 32'h0000_1000, 0, "R13");
        access(1, 0, 32'h0000_3000, 0, "R13");
        @(posedge clk); #1;
        i_req = 1; i_addr = 32'h0000_1000; d_req = 1; d_we = 0; d_addr = 32'h0000_3000;
        @(negedge clk);
        check(i_ready == 1 && d_ready == 0, "R13", "fetch first", {i_ready, d_ready}, 2'b10);
        @(posedge clk); #1;
        i_req = 0;
        @(negedge clk);
        check(d_ready == 1 && d_rdata == mem_rd(32'h0000_3000), "R13", "load next",
              d_rdata, mem_rd(32'h0000_3000));
        @(posedge clk); #1;
        d_req = 0;

        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule